// File: doc/BRIEF.md
# Six-pin bidirectional port with open-drain timer tap

This block is one six-pin general-purpose I/O port as seen by a small processor. The bus side loads two registers with separate write strobes: an output data latch and a direction mask. It also has a bit-update strobe, which rewrites the latch from the pin levels read back with one chosen bit replaced. Two separate read strobes return either the pin levels or the direction mask one cycle later. The pad side sends out a data bit and an output enable for each pin, and takes in a raw level for each pin.

Every pin drives its latch bit when its direction bit is 0 and floats when that bit is 1. Pin 4 differs: it can only pull low. Its synchronised input level also drives a timer clock output. An external analog-select mask marks the pins being used as analog inputs. For pins that can be analog, that mask forces the digital input to 0, and the direction bits still decide the drivers. Reset sets every direction bit, so every pin comes up as a floating input.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low, the data latch is 0, every direction bit is 1, pin_oe is 0, pin_out is 0, rd_data is 0 and both synchroniser stages are 0.
- R2: A cycle with port_wr high loads wdata[5:0] into the data latch. On every pin other than pin 4, pin_out equals its latch bit from the next cycle on.
- R3: On every pin other than pin 4, pin_oe is the inverse of its direction bit.
- R4: pin_out[4] is always 0. pin_oe[4] is 1 only when direction bit 4 is 0 and latch bit 4 is 0. tmr_clk equals the synchronised level of pin 4.
- R5: A cycle with dir_wr high loads wdata[5:0] into the direction register. wdata[7:6] is discarded, and a read of the direction register returns 0 in bits 7:6.
- R6: A cycle with port_rd high puts {2'b00, digital pin levels} on rd_data at the next edge. These are the synchronised levels, not the latch. A cycle with dir_rd high and port_rd low returns {2'b00, direction}. port_rd has priority.
- R7: A pin_in change first reaches the port read value two edges later. A port_rd in the cycle after the change and in the cycle after that still returns the old level.
- R8: A pin whose ana_sel bit is 1 and which is analog-capable (pins 0 to 3 and 5) reads 0 on the digital path. Pin 4 ignores ana_sel. The direction bits still control pin_oe for analog pins.
- R9: A cycle with bit_wr high and port_wr low loads the digital pin levels into the latch with bit bit_idx replaced by bit_val. When bit_idx is 6 or 7 the latch is unchanged. When port_wr is also high, port_wr wins.
- R10: rd_data holds its value in any cycle with neither read strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wdata | input | 8 | Write data for the latch and direction writes |
| port_wr | input | 1 | Load the data latch from wdata |
| dir_wr | input | 1 | Load the direction register from wdata |
| port_rd | input | 1 | Capture the digital pin levels into rd_data |
| dir_rd | input | 1 | Capture the direction register into rd_data |
| bit_wr | input | 1 | Read-modify-write of one latch bit |
| bit_idx | input | 3 | Bit position for bit_wr |
| bit_val | input | 1 | New value for the chosen bit |
| rd_data | output | 8 | Registered read data |
| ana_sel | input | 6 | External analog-select mask, 1 = analog |
| pin_in | input | 6 | Raw pad input levels |
| pin_out | output | 6 | Pad output data |
| pin_oe | output | 6 | Pad output enable, 1 = drive |
| tmr_clk | output | 1 | Synchronised level of pin 4 for the timer |

## Verification
The hardest case to reach is a bit update whose result differs from a plain update of the latch. This happens when the pin levels disagree with the latch: an input pin held high, the open-drain pin pulled low, or an analog pin that reads 0. The stimulus creates this by loading a latch value, then driving pin_in to a different pattern, with some pins marked analog. It waits for the two synchroniser stages to settle before issuing bit_wr. It also tries the out-of-range bit positions 6 and 7 and a bit_wr that collides with port_wr. A long random phase with all strobes and pins toggling follows, and the behavioural model is compared on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    RSEL_HOLD = 2'd0,
    RSEL_PINS = 2'd1,
    RSEL_DIR  = 2'd2
  } rsel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] mid_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      out_q <= '0;
    end else begin
      mid_q <= d;
      out_q <= mid_q;
    end
  end

  assign q = out_q;

  p_sync_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_q == $past(mid_q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int W  = 6,
  parameter int BW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] wdata,
  input  logic          port_wr,
  input  logic          dir_wr,
  input  logic          bit_wr,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  input  logic [W-1:0]  pin_dig,
  output logic [W-1:0]  lat,
  output logic [W-1:0]  dir
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] dir_q, dir_d;
  logic         idx_ok;
  logic         lat_en;

  assign idx_ok = int'(bit_idx) < W;
  assign lat_en = port_wr | (bit_wr & idx_ok);

  always_comb begin
    lat_d = lat_q;
    if (port_wr) begin
      lat_d = wdata[W-1:0];
    end else if (bit_wr && idx_ok) begin
      lat_d          = pin_dig;
      lat_d[bit_idx] = bit_val;
    end
  end

  always_comb begin
    dir_d = dir_q;
    if (dir_wr) dir_d = wdata[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
    end else if (dir_wr) begin
      dir_q <= dir_d;
    end
  end

  assign lat = lat_q;
  assign dir = dir_q;

  p_dir_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> dir_q == $past(wdata[W-1:0]));
  p_port_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> lat_q == $past(wdata[W-1:0]));
  p_bad_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && !port_wr && int'(bit_idx) >= W) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W      = 6,
  parameter int OD_PIN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lat,
  input  logic [W-1:0] dir,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar gi = 0; gi < W; gi++) begin : g_pin
    if (gi == OD_PIN) begin : g_od
      assign pin_out[gi] = 1'b0;
      assign pin_oe[gi]  = ~dir[gi] & ~lat[gi];
      p_od_no_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[gi] |-> !pin_out[gi] && !lat[gi]);
    end else begin : g_pp
      assign pin_out[gi] = lat[gi];
      assign pin_oe[gi]  = ~dir[gi];
    end
    p_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dir[gi] |-> !pin_oe[gi]);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int          W       = 6,
  parameter int          BW      = 8,
  parameter int          OD_PIN  = 4,
  parameter logic [W-1:0] ANA_CAP = 6'b10_1111,
  localparam int         IW      = (BW > 1) ? $clog2(BW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] wdata,
  input  logic          port_wr,
  input  logic          dir_wr,
  input  logic          port_rd,
  input  logic          dir_rd,
  input  logic          bit_wr,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [BW-1:0] rd_data,
  input  logic [W-1:0]  ana_sel,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          tmr_clk
);
  import gpio_pkg::*;

  logic [W-1:0]  pin_s;
  logic [W-1:0]  ana_eff;
  logic [W-1:0]  pin_dig;
  logic [W-1:0]  lat;
  logic [W-1:0]  dir;
  logic [BW-1:0] rd_q, rd_d;
  rsel_e         rsel;

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  assign ana_eff = ana_sel & ANA_CAP;
  assign pin_dig = pin_s & ~ana_eff;

  gpio_regs #(.W(W), .BW(BW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .port_wr(port_wr), .dir_wr(dir_wr), .bit_wr(bit_wr),
    .bit_idx(bit_idx), .bit_val(bit_val), .pin_dig(pin_dig),
    .lat(lat), .dir(dir)
  );

  gpio_pad_ctl #(.W(W), .OD_PIN(OD_PIN)) u_pad (
    .clk(clk), .rst_n(rst_n), .lat(lat), .dir(dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    if (port_rd)     rsel = RSEL_PINS;
    else if (dir_rd) rsel = RSEL_DIR;
    else             rsel = RSEL_HOLD;
  end

  always_comb begin
    unique case (rsel)
      RSEL_PINS: rd_d = {{(BW-W){1'b0}}, pin_dig};
      RSEL_DIR:  rd_d = {{(BW-W){1'b0}}, dir};
      default:   rd_d = rd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rsel != RSEL_HOLD) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
  assign tmr_clk = pin_s[OD_PIN];

  p_rd_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BW-1:W] == '0);
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_rd && !dir_rd) |=> $stable(rd_data));
  p_tmr_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tmr_clk == $past(u_sync.mid_q[OD_PIN]));
  for (genvar ai = 0; ai < W; ai++) begin : g_ana_chk
    if (ANA_CAP[ai]) begin : g_cap
      p_ana_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && ana_sel[ai]) |=> !rd_data[ai]);
    end
  end
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wdata = '0;
  logic       port_wr = 1'b0, dir_wr = 1'b0, port_rd = 1'b0, dir_rd = 1'b0;
  logic       bit_wr = 1'b0, bit_val = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [5:0] ana_sel = '0, pin_in = '0;
  logic [7:0] rd_data;
  logic [5:0] pin_out, pin_oe;
  logic       tmr_clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural model state
  logic [5:0] m_lat, m_dir;
  logic [7:0] m_rd;
  logic [5:0] m_hist[$];

  always #2.5 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .port_wr(port_wr),
    .dir_wr(dir_wr), .port_rd(port_rd), .dir_rd(dir_rd), .bit_wr(bit_wr),
    .bit_idx(bit_idx), .bit_val(bit_val), .rd_data(rd_data),
    .ana_sel(ana_sel), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .tmr_clk(tmr_clk)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] m_dig();
    return m_hist[0] & ~(ana_sel & 6'b10_1111);
  endfunction

  task automatic model_edge();
    logic [5:0] d;
    if (!rst_n) begin
      m_lat = '0; m_dir = '1; m_rd = '0;
      m_hist = '{6'h00, 6'h00};
    end else begin
      d = m_dig();
      if (port_wr) m_lat = wdata[5:0];
      else if (bit_wr && bit_idx < 3'd6) begin
        m_lat = d;
        m_lat[bit_idx] = bit_val;
      end
      if (port_rd) m_rd = {2'b00, d};
      else if (dir_rd) m_rd = {2'b00, m_dir};
      if (dir_wr) m_dir = wdata[5:0];
      void'(m_hist.pop_front());
      m_hist.push_back(pin_in);
    end
  endtask

  task automatic compare_all();
    logic [5:0] e_out, e_oe;
    e_out = m_lat & 6'b10_1111;
    e_oe  = ~m_dir & ~(6'b01_0000 & m_lat);
    chk("R2 pin_out", {2'b00, pin_out}, {2'b00, e_out});
    chk("R3 pin_oe", {2'b00, pin_oe}, {2'b00, e_oe});
    chk("R4 tmr_clk", {7'd0, tmr_clk}, {7'd0, m_hist[0][4]});
    chk("R6 rd_data", rd_data, m_rd);
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic idle();
    port_wr = 0; dir_wr = 0; port_rd = 0; dir_rd = 0; bit_wr = 0;
  endtask

  initial begin
    m_lat = '0; m_dir = '1; m_rd = '0;
    m_hist = '{6'h00, 6'h00};
    @(negedge clk);
    pin_in = 6'h3F;
    step(); step();
    chk("R1 oe in reset", {2'b00, pin_oe}, 8'h00);
    chk("R1 out in reset", {2'b00, pin_out}, 8'h00);
    chk("R1 rd in reset", rd_data, 8'h00);
    chk("R1 tmr in reset", {7'd0, tmr_clk}, 8'h00);
    pin_in = 6'h00;
    rst_n = 1'b1;
    step(); step();

    // R5: direction write, upper bits dropped
    dir_wr = 1; wdata = 8'hC0; step(); idle();
    dir_rd = 1; step(); idle();
    chk("R5 dir readback", rd_data, 8'h00);

    // R2/R4 latch drive
    port_wr = 1; wdata = 8'h3F; step(); idle();
    chk("R2 all high", {2'b00, pin_out}, 8'h2F);
    chk("R4 od off when latch 1", {7'd0, pin_oe[4]}, 8'h00);
    port_wr = 1; wdata = 8'h00; step(); idle();
    chk("R4 od pulls low", {7'd0, pin_oe[4]}, 8'h01);
    chk("R3 all driven", {2'b00, pin_oe}, 8'h3F);

    // R7: two-stage latency
    pin_in = 6'h15; port_rd = 1;
    step(); chk("R7 first edge old", rd_data, 8'h00);
    step(); chk("R7 second edge old", rd_data, 8'h00);
    step(); chk("R7 third edge new", rd_data, 8'h15);
    idle();
    chk("R4 tmr follows pin4", {7'd0, tmr_clk}, 8'h01);

    // R10: hold without strobe
    pin_in = 6'h2A; step(); step(); step();
    chk("R10 rd held", rd_data, 8'h15);

    // R8: analog pins read zero, pin 4 unaffected
    ana_sel = 6'h3F; pin_in = 6'h3F; step(); step();
    port_rd = 1; step(); idle();
    chk("R8 analog read", rd_data, 8'h10);
    chk("R8 dir still drives", {2'b00, pin_oe}, 8'h3F);
    // R6: dir read under port read priority
    dir_rd = 1; port_rd = 1; step(); idle();
    chk("R6 port_rd priority", rd_data, 8'h10);

    // R9: read-modify-write against differing pin levels
    ana_sel = 6'h01; port_wr = 1; wdata = 8'h3F; step(); idle();
    pin_in = 6'h0A; step(); step();
    bit_wr = 1; bit_idx = 3'd2; bit_val = 1; step(); idle();
    chk("R9 rmw from pins", {2'b00, pin_out}, 8'h0E);
    bit_wr = 1; bit_idx = 3'd6; bit_val = 1; step();
    bit_idx = 3'd7; step(); idle();
    chk("R9 bad index ignored", {2'b00, pin_out}, 8'h0E);
    bit_wr = 1; bit_idx = 3'd0; bit_val = 1; port_wr = 1; wdata = 8'h21; step(); idle();
    chk("R9 port write wins", {2'b00, pin_out}, 8'h21);
    ana_sel = 6'h00;

    // random phase with per-cycle model comparison
    for (int i = 0; i < 2000; i++) begin
      wdata = 8'($urandom); pin_in = 6'($urandom); ana_sel = 6'($urandom);
      port_wr = ($urandom % 5) == 0; dir_wr = ($urandom % 5) == 0;
      port_rd = ($urandom % 3) == 0; dir_rd = ($urandom % 3) == 0;
      bit_wr = ($urandom % 4) == 0; bit_idx = 3'($urandom); bit_val = 1'($urandom);
      if (i == 1000) rst_n = 1'b0;
      if (i == 1003) rst_n = 1'b1;
      step();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000 cycles", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule